// File: doc/BRIEF.md
# Burst-of-two DDR SRAM interface

This block is a synchronous memory front end with one shared command and address path and double-data-rate data. Every address names a pair of words. A command is taken on a rising edge of the K clock when the load strobe is high, and the select input says read or write. Write data follows late: the first word is sampled on the next rising K edge and the second on the falling edge after it, which is the rising edge of the complementary clock. Read data leaves on both clock phases. The first word is driven during the high phase and the second during the following low phase. A data-valid flag covers exactly those two half-cycles. Echo clocks copy K and its complement, so a receiver can capture the data with them alone.

A latency-mode input selects where the read burst sits. With the input high, the burst starts on the second rising edge after the command. With the input low, it starts on the first rising edge, as on an older DDR memory. The mode is changed only while no command is in flight.

Internally each command is decoded into one of three kinds: CMD_IDLE (strobe low), CMD_WRITE and CMD_READ. The kind moves through two capture stages on rising edges. A stage-1 CMD_WRITE opens the write-data window, and the read launch point is stage 2 or stage 1, depending on the mode. A write waits in a hold register until the rising edge that follows its second word. On that edge it is merged into the array under its lane enables. A read whose first word is launched while that write is still held is served from the hold register.

The word width is a parameter. The number of addresses scales with it: the 8-bit and 9-bit widths have four times the addresses of the 36-bit width, and the 18-bit width has twice as many.

Top module: `b2d_sram`

## Requirements
- R1: After reset and while no read has been issued, rd_valid is low in both clock phases.
- R2: A write is captured when cmd_load=1 and cmd_read=0 on a rising edge. Word 0 is sampled from wr_data on the next rising edge and word 1 on the falling edge after that. They are stored as words 0 and 1 of that address.
- R3: A read burst drives word 0 of the address during a high phase of k_clk and word 1 during the low phase that follows.
- R4: With lat_mode=1, word 0 of a read captured on rising edge n is on rd_data during the high phase after edge n+2, and rd_valid is low during the high phase after edge n+1.
- R5: With lat_mode=0, word 0 of a read captured on rising edge n is on rd_data during the high phase after edge n+1.
- R6: rd_valid is high during the two half-cycles that carry a read burst and low in the half-cycles directly before and after it.
- R7: echo_k equals k_clk and echo_kn equals its complement.
- R8: Lane i is bits [i*LANE_W +: LANE_W] of a word. For the default 18-bit width there are two lanes of 9 bits. When wr_lane_en[i] is 1 while a write word is sampled, that lane is written. When it is 0, the lane keeps its old contents.
- R9: A read captured on the rising edge right after a write to the same address (lat_mode=0) returns the new data, merged under the lane enables, in both words.
- R10: Reads captured on two consecutive rising edges give two bursts back to back, and rd_valid stays high for all four half-cycles.
- R11: With cmd_load=0 nothing happens, whatever cmd_read, cmd_addr and wr_data carry: rd_valid stays low and the array keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| k_clk | input | 1 | K clock; its falling edge acts as the complementary-clock rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lat_mode | input | 1 | 1: read latency 2.0 cycles; 0: 1.0 cycle |
| cmd_load | input | 1 | Command strobe, sampled on rising edges |
| cmd_read | input | 1 | 1: read, 0: write, qualified by cmd_load |
| cmd_addr | input | ADDR_W | Pair address |
| wr_data | input | WORD_W | Write word, sampled on both edges during the write window |
| wr_lane_en | input | NLANES | Per-lane write enable, sampled with each write word |
| rd_data | output | WORD_W | Read word, word 0 in the high phase and word 1 in the low phase |
| rd_valid | output | 1 | High while rd_data carries read data |
| echo_k | output | 1 | Echo of k_clk |
| echo_kn | output | 1 | Echo of the complement of k_clk |

## Verification
The critical collision comes when a held write commits to the array on the same rising edge that launches the first word of a read of that same address. It is provoked in 1.0-cycle mode by issuing a write and then a read of that address on the next rising edge, once with all lanes enabled on an unwritten address and once with a partial lane mask over known data. Both read words are compared against a bench model that applies the lane merge itself, so a missing forward or a wrong merge order shows up as a data mismatch.

// File: rtl/b2d_pkg.sv
package b2d_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2
    } b2d_cmd_e;

    // write-enable lanes per word
    function automatic int lane_count(input int width);
        if (width >= 36)      return 4;
        else if (width >= 18) return 2;
        else                  return 1;
    endfunction

    // address multiplier relative to the widest word
    function automatic int depth_mul(input int width);
        if (width >= 36)      return 1;
        else if (width >= 18) return 2;
        else                  return 4;
    endfunction

endpackage

// File: rtl/b2d_cmd_pipe.sv
module b2d_cmd_pipe
    import b2d_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              k_clk,
    input  logic              rst_n,
    input  logic              lat_mode,
    input  logic              cmd_load,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              wcap_v,
    output logic [ADDR_W-1:0] wcap_addr,
    output logic              rsrc_v,
    output logic [ADDR_W-1:0] rsrc_addr
);

    b2d_cmd_e          kind_next;
    b2d_cmd_e          s1_kind, s2_kind;
    logic [ADDR_W-1:0] s1_addr, s2_addr;

    always_comb begin
        unique case ({cmd_load, cmd_read})
            2'b10:   kind_next = CMD_WRITE;
            2'b11:   kind_next = CMD_READ;
            default: kind_next = CMD_IDLE;
        endcase
    end

    always_ff @(posedge k_clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_kind <= CMD_IDLE;
            s2_kind <= CMD_IDLE;
            s1_addr <= '0;
            s2_addr <= '0;
        end else begin
            s1_kind <= kind_next;
            s1_addr <= cmd_addr;
            s2_kind <= s1_kind;
            s2_addr <= s1_addr;
        end
    end

    always_comb begin
        wcap_v    = (s1_kind == CMD_WRITE);
        wcap_addr = s1_addr;
        unique case (lat_mode)
            1'b1: begin
                rsrc_v    = (s2_kind == CMD_READ);
                rsrc_addr = s2_addr;
            end
            default: begin
                rsrc_v    = (s1_kind == CMD_READ);
                rsrc_addr = s1_addr;
            end
        endcase
    end

    // R4: long latency launches a read that was in stage 1 one edge earlier
    a_r4_lat2_two_back: assert property (@(posedge k_clk) disable iff (!rst_n)
        (lat_mode && rsrc_v) |-> $past(s1_kind == CMD_READ));

    // R5: short latency launches a read strobed on the previous edge
    a_r5_lat1_one_back: assert property (@(posedge k_clk) disable iff (!rst_n)
        (!lat_mode && rsrc_v) |-> $past(cmd_load && cmd_read));

    // R11: no strobe, no write window
    a_r11_idle_no_write: assert property (@(posedge k_clk) disable iff (!rst_n)
        $past(!cmd_load) |-> !wcap_v);

endmodule

// File: rtl/b2d_store.sv
module b2d_store #(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 5,
    parameter int NLANES = 2,
    localparam int LANE_W = WORD_W / NLANES,
    localparam int SLOTS  = 2 << ADDR_W
) (
    input  logic              k_clk,
    input  logic              rst_n,
    input  logic              wcap_v,
    input  logic [ADDR_W-1:0] wcap_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [NLANES-1:0] wr_lane_en,
    input  logic [ADDR_W-1:0] fetch0_addr,
    input  logic [ADDR_W-1:0] fetch1_addr,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1
);

    logic [WORD_W-1:0] mem [SLOTS];

    logic              hold_v;
    logic [ADDR_W-1:0] hold_a;
    logic [WORD_W-1:0] hold_w0, hold_w1;
    logic [NLANES-1:0] hold_e0, hold_e1;

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] fresh,
        input logic [NLANES-1:0] en,
        input logic [WORD_W-1:0] old
    );
        logic [WORD_W-1:0] res;
        res = old;
        for (int i = 0; i < NLANES; i++) begin
            if (en[i]) res[i*LANE_W +: LANE_W] = fresh[i*LANE_W +: LANE_W];
        end
        return res;
    endfunction

    // rising edge: commit the held write, then take word 0 of a new one
    always_ff @(posedge k_clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_v  <= 1'b0;
            hold_a  <= '0;
            hold_w0 <= '0;
            hold_e0 <= '0;
        end else begin
            hold_v <= wcap_v;
            if (wcap_v) begin
                hold_a  <= wcap_addr;
                hold_w0 <= wr_data;
                hold_e0 <= wr_lane_en;
            end
        end
    end

    // falling edge: word 1 of the held write
    always_ff @(negedge k_clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_w1 <= '0;
            hold_e1 <= '0;
        end else if (hold_v) begin
            hold_w1 <= wr_data;
            hold_e1 <= wr_lane_en;
        end
    end

    always_ff @(posedge k_clk) begin
        if (hold_v) begin
            mem[{hold_a, 1'b0}] <= lane_merge(hold_w0, hold_e0, mem[{hold_a, 1'b0}]);
            mem[{hold_a, 1'b1}] <= lane_merge(hold_w1, hold_e1, mem[{hold_a, 1'b1}]);
        end
    end

    // word 0 forwards a write still in the hold register
    always_comb begin
        if (hold_v && (hold_a == fetch0_addr))
            word0 = lane_merge(hold_w0, hold_e0, mem[{fetch0_addr, 1'b0}]);
        else
            word0 = mem[{fetch0_addr, 1'b0}];
        word1 = mem[{fetch1_addr, 1'b1}];
    end

    // R2: a full write lands in the array on the commit edge
    a_r2_word0_committed: assert property (@(posedge k_clk) disable iff (!rst_n)
        (hold_v && (&hold_e0)) |=> (mem[{$past(hold_a), 1'b0}] == $past(hold_w0)));

    a_r2_word1_committed: assert property (@(posedge k_clk) disable iff (!rst_n)
        (hold_v && (&hold_e1)) |=> (mem[{$past(hold_a), 1'b1}] == $past(hold_w1)));

    // R8: a disabled lane keeps its old contents
    a_r8_lane_kept: assert property (@(posedge k_clk) disable iff (!rst_n)
        (hold_v && !hold_e0[0]) |=>
        (mem[{$past(hold_a), 1'b0}][LANE_W-1:0] == $past(mem[{hold_a, 1'b0}][LANE_W-1:0])));

endmodule

// File: rtl/b2d_ddr_out.sv
module b2d_ddr_out #(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 5
) (
    input  logic              k_clk,
    input  logic              rst_n,
    input  logic              rsrc_v,
    input  logic [ADDR_W-1:0] rsrc_addr,
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    output logic [ADDR_W-1:0] launch_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              echo_k,
    output logic              echo_kn
);

    logic              hi_v, lo_v;
    logic [WORD_W-1:0] hi_q, lo_q;

    always_ff @(posedge k_clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_v        <= 1'b0;
            hi_q        <= '0;
            launch_addr <= '0;
        end else begin
            hi_v        <= rsrc_v;
            hi_q        <= word0;
            launch_addr <= rsrc_addr;
        end
    end

    always_ff @(negedge k_clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_v <= 1'b0;
            lo_q <= '0;
        end else begin
            lo_v <= hi_v;
            lo_q <= word1;
        end
    end

    always_comb begin
        rd_data  = k_clk ? hi_q : lo_q;
        rd_valid = k_clk ? hi_v : lo_v;
        echo_k   = k_clk;
        echo_kn  = ~k_clk;
    end

    // R6: the low-phase flag always completes the burst opened in the high phase
    a_r6_halves_agree: assert property (@(posedge k_clk) disable iff (!rst_n)
        hi_v == lo_v);

endmodule

// File: rtl/b2d_sram.sv
module b2d_sram
    import b2d_pkg::*;
#(
    parameter int WORD_W     = 18,
    parameter int BASE_PAIRS = 16,
    localparam int PAIRS  = BASE_PAIRS * depth_mul(WORD_W),
    localparam int ADDR_W = $clog2(PAIRS),
    localparam int NLANES = lane_count(WORD_W)
) (
    input  logic              k_clk,
    input  logic              rst_n,
    input  logic              lat_mode,
    input  logic              cmd_load,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [NLANES-1:0] wr_lane_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              echo_k,
    output logic              echo_kn
);

    logic              wcap_v, rsrc_v;
    logic [ADDR_W-1:0] wcap_addr, rsrc_addr, launch_addr;
    logic [WORD_W-1:0] word0, word1;

    b2d_cmd_pipe #(.ADDR_W(ADDR_W)) u_cmd (
        .k_clk     (k_clk),
        .rst_n     (rst_n),
        .lat_mode  (lat_mode),
        .cmd_load  (cmd_load),
        .cmd_read  (cmd_read),
        .cmd_addr  (cmd_addr),
        .wcap_v    (wcap_v),
        .wcap_addr (wcap_addr),
        .rsrc_v    (rsrc_v),
        .rsrc_addr (rsrc_addr)
    );

    b2d_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NLANES(NLANES)) u_store (
        .k_clk       (k_clk),
        .rst_n       (rst_n),
        .wcap_v      (wcap_v),
        .wcap_addr   (wcap_addr),
        .wr_data     (wr_data),
        .wr_lane_en  (wr_lane_en),
        .fetch0_addr (rsrc_addr),
        .fetch1_addr (launch_addr),
        .word0       (word0),
        .word1       (word1)
    );

    b2d_ddr_out #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_out (
        .k_clk       (k_clk),
        .rst_n       (rst_n),
        .rsrc_v      (rsrc_v),
        .rsrc_addr   (rsrc_addr),
        .word0       (word0),
        .word1       (word1),
        .launch_addr (launch_addr),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .echo_k      (echo_k),
        .echo_kn     (echo_kn)
    );

endmodule

// File: tb/b2d_sram_tb_top.sv
module b2d_sram_tb_top;

    localparam int WW = 18;
    localparam int AW = 5;
    localparam int NL = 2;
    localparam int LW = 9;

    logic          k_clk = 1'b0;
    logic          rst_n;
    logic          lat_mode;
    logic          cmd_load, cmd_read;
    logic [AW-1:0] cmd_addr;
    logic [WW-1:0] wr_data;
    logic [NL-1:0] wr_lane_en;
    logic [WW-1:0] rd_data;
    logic          rd_valid, echo_k, echo_kn;

    int n_cmp = 0;
    int n_bad = 0;
    logic [WW-1:0] ref_mem [64];

    always #4 k_clk = ~k_clk;

    b2d_sram #(.WORD_W(WW), .BASE_PAIRS(16)) dut_i (
        .k_clk(k_clk), .rst_n(rst_n), .lat_mode(lat_mode),
        .cmd_load(cmd_load), .cmd_read(cmd_read), .cmd_addr(cmd_addr),
        .wr_data(wr_data), .wr_lane_en(wr_lane_en),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .echo_k(echo_k), .echo_kn(echo_kn)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [WW-1:0] mrg(input logic [WW-1:0] fresh,
                                          input logic [NL-1:0] en,
                                          input logic [WW-1:0] old);
        logic [WW-1:0] r;
        r = old;
        for (int i = 0; i < NL; i++)
            if (en[i]) r[i*LW +: LW] = fresh[i*LW +: LW];
        return r;
    endfunction

    task automatic issue(input logic rd, input logic [AW-1:0] a);
        @(negedge k_clk); #1;
        cmd_load = 1'b1; cmd_read = rd; cmd_addr = a;
        @(posedge k_clk); #1;
        cmd_load = 1'b0; cmd_read = 1'b0;
    endtask

    task automatic wr_burst(input logic [AW-1:0] a, input logic [WW-1:0] w0,
                            input logic [WW-1:0] w1, input logic [NL-1:0] e0,
                            input logic [NL-1:0] e1);
        issue(1'b0, a);
        @(negedge k_clk); #1;
        wr_data = w0; wr_lane_en = e0;
        @(posedge k_clk); #1;
        wr_data = w1; wr_lane_en = e1;
        ref_mem[{a, 1'b0}] = mrg(w0, e0, ref_mem[{a, 1'b0}]);
        ref_mem[{a, 1'b1}] = mrg(w1, e1, ref_mem[{a, 1'b1}]);
    endtask

    task automatic rd_burst(input string req, input logic [AW-1:0] a, input int lat);
        logic [WW-1:0] e0, e1;
        e0 = ref_mem[{a, 1'b0}];
        e1 = ref_mem[{a, 1'b1}];
        issue(1'b1, a);
        @(negedge k_clk); #2;
        chk({req, " valid low in low phase before burst"}, rd_valid, 1'b0);
        if (lat == 2) begin
            @(posedge k_clk); #2;
            chk({req, " valid low one edge after read"}, rd_valid, 1'b0);
        end
        @(posedge k_clk); #2;
        chk({req, " word0 valid"}, rd_valid, 1'b1);
        chk({req, " word0 data"}, rd_data, e0);
        @(negedge k_clk); #2;
        chk({req, " word1 valid"}, rd_valid, 1'b1);
        chk({req, " word1 data"}, rd_data, e1);
        @(posedge k_clk); #2;
        chk({req, " valid low after burst"}, rd_valid, 1'b0);
    endtask

    // R1 R7
    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            @(posedge k_clk); #2;
            chk("R1 valid low high phase", rd_valid, 1'b0);
            chk("R7 echo_k high phase", echo_k, 1'b1);
            chk("R7 echo_kn high phase", echo_kn, 1'b0);
            @(negedge k_clk); #2;
            chk("R1 valid low low phase", rd_valid, 1'b0);
            chk("R7 echo_k low phase", echo_k, 1'b0);
            chk("R7 echo_kn low phase", echo_kn, 1'b1);
        end
    endtask

    // R2 R3 R4 R6
    task automatic t_lat2();
        lat_mode = 1'b1;
        wr_burst(5'd0,  18'h2A5C3, 18'h15A3C, 2'b11, 2'b11);
        wr_burst(5'd31, 18'h3FFFF, 18'h00001, 2'b11, 2'b11);
        wr_burst(5'd3,  18'h12345, 18'h2BCDE, 2'b11, 2'b11);
        rd_burst("R2 R3 R4 R6 addr0",  5'd0,  2);
        rd_burst("R2 R3 R4 R6 addr31", 5'd31, 2);
        rd_burst("R2 R3 R4 R6 addr3",  5'd3,  2);
    endtask

    // R5 R6
    task automatic t_lat1();
        repeat (3) @(posedge k_clk);
        lat_mode = 1'b0;
        rd_burst("R5 R6 addr31", 5'd31, 1);
        rd_burst("R5 R6 addr0",  5'd0,  1);
    endtask

    // R8
    task automatic t_mask();
        wr_burst(5'd3, 18'h00000, 18'h3FFFF, 2'b01, 2'b10);
        rd_burst("R8 lane mask addr3", 5'd3, 1);
    endtask

    // R11
    task automatic t_idle();
        @(negedge k_clk); #1;
        cmd_load = 1'b0; cmd_read = 1'b1; cmd_addr = 5'd3;
        wr_data = 18'h0F0F0; wr_lane_en = 2'b11;
        for (int i = 0; i < 3; i++) begin
            @(posedge k_clk); #2;
            chk("R11 idle valid high phase", rd_valid, 1'b0);
            cmd_read = ~cmd_read;
            wr_data = ~wr_data;
            @(negedge k_clk); #2;
            chk("R11 idle valid low phase", rd_valid, 1'b0);
        end
        cmd_read = 1'b0;
        rd_burst("R11 contents unchanged addr3", 5'd3, 1);
    endtask

    task automatic fwd_pair(input string req, input logic [AW-1:0] a,
                            input logic [WW-1:0] w0, input logic [WW-1:0] w1,
                            input logic [NL-1:0] e0, input logic [NL-1:0] e1);
        logic [WW-1:0] x0, x1;
        issue(1'b0, a);
        @(negedge k_clk); #1;
        cmd_load = 1'b1; cmd_read = 1'b1; cmd_addr = a;
        wr_data = w0; wr_lane_en = e0;
        @(posedge k_clk); #1;
        cmd_load = 1'b0; cmd_read = 1'b0;
        wr_data = w1; wr_lane_en = e1;
        ref_mem[{a, 1'b0}] = mrg(w0, e0, ref_mem[{a, 1'b0}]);
        ref_mem[{a, 1'b1}] = mrg(w1, e1, ref_mem[{a, 1'b1}]);
        x0 = ref_mem[{a, 1'b0}];
        x1 = ref_mem[{a, 1'b1}];
        @(negedge k_clk); #2;
        chk({req, " valid low before burst"}, rd_valid, 1'b0);
        @(posedge k_clk); #2;
        chk({req, " word0 valid"}, rd_valid, 1'b1);
        chk({req, " word0 forwarded"}, rd_data, x0);
        @(negedge k_clk); #2;
        chk({req, " word1 valid"}, rd_valid, 1'b1);
        chk({req, " word1 data"}, rd_data, x1);
        @(posedge k_clk); #2;
        chk({req, " valid low after burst"}, rd_valid, 1'b0);
    endtask

    // R9
    task automatic t_forward();
        lat_mode = 1'b0;
        fwd_pair("R9 full write then read addr9", 5'd9, 18'h1D2E3, 18'h26B7A, 2'b11, 2'b11);
        wr_burst(5'd7, 18'h11111, 18'h22222, 2'b11, 2'b11);
        fwd_pair("R9 masked write then read addr7", 5'd7, 18'h3C3C3, 18'h05A5A, 2'b10, 2'b01);
    endtask

    // R10
    task automatic t_b2b();
        repeat (3) @(posedge k_clk);
        lat_mode = 1'b1;
        @(negedge k_clk); #1;
        cmd_load = 1'b1; cmd_read = 1'b1; cmd_addr = 5'd0;
        @(posedge k_clk); #1;
        @(negedge k_clk); #1;
        cmd_addr = 5'd31;
        @(posedge k_clk); #1;
        cmd_load = 1'b0; cmd_read = 1'b0;
        @(posedge k_clk); #2;
        chk("R10 first word0 valid", rd_valid, 1'b1);
        chk("R10 first word0 data", rd_data, ref_mem[0]);
        @(negedge k_clk); #2;
        chk("R10 first word1 valid", rd_valid, 1'b1);
        chk("R10 first word1 data", rd_data, ref_mem[1]);
        @(posedge k_clk); #2;
        chk("R10 second word0 valid", rd_valid, 1'b1);
        chk("R10 second word0 data", rd_data, ref_mem[62]);
        @(negedge k_clk); #2;
        chk("R10 second word1 valid", rd_valid, 1'b1);
        chk("R10 second word1 data", rd_data, ref_mem[63]);
        @(posedge k_clk); #2;
        chk("R10 valid low after pair", rd_valid, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; lat_mode = 1'b1;
        cmd_load = 1'b0; cmd_read = 1'b0; cmd_addr = '0;
        wr_data = '0; wr_lane_en = '0;
        for (int i = 0; i < 64; i++) ref_mem[i] = 'x;
        repeat (3) @(posedge k_clk);
        @(negedge k_clk); #1;
        rst_n = 1'b1;
        t_reset();
        t_lat2();
        t_lat1();
        t_mask();
        t_idle();
        t_forward();
        t_b2b();
        repeat (2) @(posedge k_clk);
        summary();
        $finish;
    end

    initial begin
        #(8 * 50000);
        n_bad++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        summary();
        $finish;
    end

endmodule